// File: doc/BRIEF.md
# Virtual-machine branch resolver

This block resolves control-flow instructions of a 64-bit register virtual machine. It accepts one instruction per cycle together with its operand values and the slot address of the instruction. One cycle later it reports whether the branch is taken and which slot to fetch next. It also raises a one-cycle call indication that carries the helper number, a one-cycle exit indication, or an illegal flag. The surrounding pipeline performs the helper call, handles the return value and fetches instructions. The resolver only makes the decision.

The low three opcode bits give the class. Class 5 compares full 64-bit operands. Class 6 compares only the low 32 bits. Opcode bit 3 picks the second operand: the immediate when 0, the source register value when 1. Opcode bits 7:4 hold the condition.

Top module: `vm_branch_unit`

## Requirements
- R1: While reset is held and in the cycle after it is released, `taken`, `call_pulse`, `exit_pulse`, `illegal` and `next_pc` are all zero.
- R2: Outputs appear on the clock edge that follows the cycle in which `issue` is high. After a cycle with `issue` low, `taken`, `call_pulse`, `exit_pulse` and `illegal` are low and `next_pc` keeps its previous value.
- R3: With opcode bit 3 at 0, the second operand is the immediate. In class 5 the immediate is sign-extended from 32 to 64 bits before the compare. With bit 3 at 1, the second operand is `src_val`.
- R4: In class 6, only bits 31:0 of both operands take part. Signed conditions treat bit 31 as the sign.
- R5: Condition 0x1 is taken when the operands are equal. Condition 0x5 is taken when they differ. Condition 0x4 is taken when the bitwise AND of the operands is nonzero.
- R6: Unsigned conditions are taken as follows: 0x2 when dst > src, 0x3 when dst >= src, 0xa when dst < src, and 0xb when dst <= src.
- R7: Signed conditions are taken as follows, using two's-complement operands: 0x6 when dst > src, 0x7 when dst >= src, 0xc when dst < src, and 0xd when dst <= src.
- R8: `next_pc` is pc + 1 + sign-extended offset when taken, and pc + 1 otherwise. Both sums wrap modulo 2^PCW.
- R9: Condition 0x0 in class 5 is always taken.
- R10: Condition 0x8 in either class gives a one-cycle `call_pulse` with `helper_id` set to the immediate. `taken` stays 0 and `next_pc` is pc + 1.
- R11: Condition 0x9 in class 5 gives a one-cycle `exit_pulse`. `taken` stays 0.
- R12: `illegal` is raised for condition 0x0 or 0x9 in class 6, for conditions 0xe and 0xf, and for any class other than 5 or 6. In that case `taken`, `call_pulse` and `exit_pulse` stay 0 and `next_pc` is pc + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | An instruction is presented this cycle |
| opcode | input | 8 | Condition, operand source and class |
| offset | input | 16 | Signed branch displacement in slots |
| imm | input | 32 | Immediate operand or helper number |
| dst_val | input | 64 | Destination register value |
| src_val | input | 64 | Source register value |
| pc | input | PCW | Slot address of the instruction |
| taken | output | 1 | Branch taken |
| next_pc | output | PCW | Slot to fetch next |
| call_pulse | output | 1 | Helper call requested |
| helper_id | output | 32 | Helper number of the last call |
| exit_pulse | output | 1 | Program return requested |
| illegal | output | 1 | Encoding not allowed |

## Verification
A call outcome and an exit outcome, or a taken branch and a call, can be in flight in consecutive cycles because each pulse is registered. The bench issues a call in one cycle and an exit in the very next. It then checks that the call indication drops in the same cycle the exit indication rises and that neither pulse lasts two cycles. A taken branch issued right after a call is judged the same way, and the helper number must survive it.

// File: rtl/vm_branch_unit.sv
module vm_branch_unit #(
  parameter int PCW  = 32,
  parameter int DW   = 64,
  parameter int IMMW = 32,
  parameter int OFFW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue,
  input  logic [7:0]      opcode,
  input  logic [OFFW-1:0] offset,
  input  logic [IMMW-1:0] imm,
  input  logic [DW-1:0]   dst_val,
  input  logic [DW-1:0]   src_val,
  input  logic [PCW-1:0]  pc,
  output logic            taken,
  output logic [PCW-1:0]  next_pc,
  output logic            call_pulse,
  output logic [IMMW-1:0] helper_id,
  output logic            exit_pulse,
  output logic            illegal
);
  localparam int HW = DW / 2;

  logic [2:0] cls;
  logic [3:0] cond;
  logic wide, narrow;
  assign cls    = opcode[2:0];
  assign cond   = opcode[7:4];
  assign wide   = (cls == 3'd5);
  assign narrow = (cls == 3'd6);

  logic [DW-1:0] imm_ext, rhs;
  assign imm_ext = {{(DW-IMMW){imm[IMMW-1]}}, imm};
  assign rhs     = opcode[3] ? src_val : imm_ext;

  logic [DW-1:0] a_u, b_u, a_s, b_s;
  assign a_u = narrow ? {{HW{1'b0}}, dst_val[HW-1:0]} : dst_val;
  assign b_u = narrow ? {{HW{1'b0}}, rhs[HW-1:0]}     : rhs;
  assign a_s = narrow ? {{HW{dst_val[HW-1]}}, dst_val[HW-1:0]} : dst_val;
  assign b_s = narrow ? {{HW{rhs[HW-1]}}, rhs[HW-1:0]}         : rhs;

  logic eq, ugt, sgt, bits;
  assign eq   = (a_u == b_u);
  assign ugt  = (a_u > b_u);
  assign sgt  = ($signed(a_s) > $signed(b_s));
  assign bits = |(a_u & b_u);

  logic go, is_call, is_exit, bad;
  always_comb begin
    go      = 1'b0;
    is_call = 1'b0;
    is_exit = 1'b0;
    bad     = 1'b0;
    case (cond)
      4'h0: if (wide) go = 1'b1; else bad = 1'b1;
      4'h1: go = eq;
      4'h2: go = ugt;
      4'h3: go = ugt | eq;
      4'h4: go = bits;
      4'h5: go = !eq;
      4'h6: go = sgt;
      4'h7: go = sgt | eq;
      4'h8: is_call = 1'b1;
      4'h9: if (wide) is_exit = 1'b1; else bad = 1'b1;
      4'ha: go = !(ugt | eq);
      4'hb: go = !ugt;
      4'hc: go = !(sgt | eq);
      4'hd: go = !sgt;
      default: bad = 1'b1;
    endcase
    if (!(wide || narrow)) begin
      bad     = 1'b1;
      go      = 1'b0;
      is_call = 1'b0;
      is_exit = 1'b0;
    end
  end

  logic [PCW-1:0] pc_inc, pc_jump;
  assign pc_inc  = pc + 1'b1;
  assign pc_jump = pc_inc + {{(PCW-OFFW){offset[OFFW-1]}}, offset};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      taken      <= 1'b0;
      next_pc    <= '0;
      call_pulse <= 1'b0;
      helper_id  <= '0;
      exit_pulse <= 1'b0;
      illegal    <= 1'b0;
    end else begin
      taken      <= issue & go;
      call_pulse <= issue & is_call;
      exit_pulse <= issue & is_exit;
      illegal    <= issue & bad;
      if (issue) next_pc <= go ? pc_jump : pc_inc;
      if (issue && is_call) helper_id <= imm;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> !(taken || call_pulse || exit_pulse || illegal)); // R2
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({taken, call_pulse, exit_pulse, illegal})); // R12
  AST_FALLTHROUGH_PC: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> (taken || next_pc == $past(pc_inc))); // R8
  AST_CALL_NEEDS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    call_pulse |-> $past(issue)); // R10
  AST_NO_NARROW_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && narrow) |=> !exit_pulse); // R11
endmodule

// File: tb/test_vm_branch_unit.sv
module test_vm_branch_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0;
  logic [7:0]  opcode = '0;
  logic [15:0] offset = '0;
  logic [31:0] imm = '0;
  logic [63:0] dst_val = '0;
  logic [63:0] src_val = '0;
  logic [31:0] pc = '0;
  logic        taken, call_pulse, exit_pulse, illegal;
  logic [31:0] next_pc, helper_id;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  vm_branch_unit i_vm_branch_unit (
    .clk(clk), .rst_n(rst_n), .issue(issue), .opcode(opcode), .offset(offset),
    .imm(imm), .dst_val(dst_val), .src_val(src_val), .pc(pc),
    .taken(taken), .next_pc(next_pc), .call_pulse(call_pulse),
    .helper_id(helper_id), .exit_pulse(exit_pulse), .illegal(illegal)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] op, input logic [15:0] off, input logic [31:0] im,
                       input logic [63:0] d, input logic [63:0] s, input logic [31:0] p);
    issue = 1'b1; opcode = op; offset = off; imm = im; dst_val = d; src_val = s; pc = p;
  endtask

  task automatic run(input string tag, input logic [7:0] op, input logic [15:0] off,
                     input logic [31:0] im, input logic [63:0] d, input logic [63:0] s,
                     input logic [31:0] p, input logic e_tk, input logic [31:0] e_pc,
                     input logic e_call, input logic e_exit, input logic e_ill);
    @(negedge clk);
    drive(op, off, im, d, s, p);
    @(negedge clk);
    issue = 1'b0;
    chk({tag, " taken"}, 64'(taken), 64'(e_tk));
    chk({tag, " next_pc"}, 64'(next_pc), 64'(e_pc));
    chk({tag, " call"}, 64'(call_pulse), 64'(e_call));
    chk({tag, " exit"}, 64'(exit_pulse), 64'(e_exit));
    chk({tag, " illegal"}, 64'(illegal), 64'(e_ill));
  endtask

  task automatic t_reset;
    chk("R1 taken", 64'(taken), 0);
    chk("R1 next_pc", 64'(next_pc), 0);
    chk("R1 pulses", 64'({call_pulse, exit_pulse, illegal}), 0);
  endtask

  task automatic t_always;
    run("R9 ja", 8'h05, 16'd3, 0, 0, 0, 32'd10, 1, 32'd14, 0, 0, 0);
  endtask

  task automatic t_equality;
    run("R5 jeq", 8'h15, 16'd2, 32'd5, 64'd5, 0, 32'd100, 1, 32'd103, 0, 0, 0);
    run("R5 jne", 8'h5d, 16'd2, 0, 64'd9, 64'd9, 32'd100, 0, 32'd101, 0, 0, 0);
    run("R5 jset", 8'h4d, 16'd4, 0, 64'h10, 64'h30, 32'd0, 1, 32'd5, 0, 0, 0);
    run("R5 jset0", 8'h4d, 16'd4, 0, 64'h10, 64'h20, 32'd0, 0, 32'd1, 0, 0, 0);
  endtask

  task automatic t_imm_ext;
    run("R3 sext hit", 8'h15, 16'd1, 32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 0, 32'd50, 1, 32'd52, 0, 0, 0);
    run("R3 sext miss", 8'h15, 16'd1, 32'hFFFF_FFFF, 64'h0000_0000_FFFF_FFFF, 0, 32'd50, 0, 32'd51, 0, 0, 0);
    run("R3 reg src", 8'h1d, 16'd1, 32'd7, 64'd8, 64'd8, 32'd50, 1, 32'd52, 0, 0, 0);
  endtask

  task automatic t_unsigned;
    run("R6 jgt", 8'h2d, 16'd1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 32'd0, 1, 32'd2, 0, 0, 0);
    run("R6 jge", 8'h3d, 16'd1, 0, 64'd1, 64'd2, 32'd0, 0, 32'd1, 0, 0, 0);
    run("R6 jlt", 8'ha5, 16'd1, 32'd4, 64'd3, 0, 32'd0, 1, 32'd2, 0, 0, 0);
    run("R6 jle", 8'hbd, 16'd1, 0, 64'd6, 64'd6, 32'd0, 1, 32'd2, 0, 0, 0);
  endtask

  task automatic t_signed;
    run("R7 jsgt", 8'h6d, 16'd1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 32'd0, 0, 32'd1, 0, 0, 0);
    run("R7 jslt", 8'hcd, 16'd1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 32'd0, 1, 32'd2, 0, 0, 0);
    run("R7 jsge", 8'h7d, 16'd1, 0, 64'd4, 64'd4, 32'd0, 1, 32'd2, 0, 0, 0);
    run("R7 jsle", 8'hdd, 16'd1, 0, 64'd2, 64'hFFFF_FFFF_FFFF_FFFB, 32'd0, 0, 32'd1, 0, 0, 0);
  endtask

  task automatic t_narrow;
    run("R4 jeq32", 8'h1e, 16'd1, 0, 64'hAAAA_0000_0000_0007, 64'h5555_0000_0000_0007, 32'd0, 1, 32'd2, 0, 0, 0);
    run("R4 jslt32", 8'hce, 16'd1, 0, 64'h0000_0000_FFFF_FFFF, 64'd1, 32'd0, 1, 32'd2, 0, 0, 0);
    run("R4 jgt32", 8'h26, 16'd1, 32'd0, 64'h1_0000_0000, 0, 32'd0, 0, 32'd1, 0, 0, 0);
  endtask

  task automatic t_pc_math;
    run("R8 back", 8'h05, 16'hFFFB, 0, 0, 0, 32'd20, 1, 32'd16, 0, 0, 0);
    run("R8 wrap", 8'h5d, 16'd7, 0, 64'd1, 64'd1, 32'hFFFF_FFFF, 0, 32'd0, 0, 0, 0);
  endtask

  task automatic t_call_exit;
    run("R10 call", 8'h85, 16'd9, 32'h1234, 0, 0, 32'd30, 0, 32'd31, 1, 0, 0);
    chk("R10 helper", 64'(helper_id), 64'h1234);
    run("R10 call32", 8'h86, 16'd9, 32'h55, 0, 0, 32'd40, 0, 32'd41, 1, 0, 0);
    chk("R10 helper32", 64'(helper_id), 64'h55);
    run("R11 exit", 8'h95, 16'd9, 0, 0, 0, 32'd60, 0, 32'd61, 0, 1, 0);
  endtask

  task automatic t_illegal;
    run("R12 ja32", 8'h06, 16'd5, 0, 0, 0, 32'd8, 0, 32'd9, 0, 0, 1);
    run("R12 exit32", 8'h96, 16'd5, 0, 0, 0, 32'd8, 0, 32'd9, 0, 0, 1);
    run("R12 code e", 8'he5, 16'd5, 0, 0, 0, 32'd8, 0, 32'd9, 0, 0, 1);
    run("R12 class4", 8'h14, 16'd5, 0, 0, 0, 32'd8, 0, 32'd9, 0, 0, 1);
  endtask

  task automatic t_idle;
    run("R2 setup", 8'h05, 16'd2, 0, 0, 0, 32'd70, 1, 32'd73, 0, 0, 0);
    @(negedge clk);
    chk("R2 idle taken", 64'(taken), 0);
    chk("R2 idle pc", 64'(next_pc), 64'd73);
  endtask

  task automatic t_overlap;
    @(negedge clk);
    drive(8'h85, 16'd0, 32'hBEEF, 0, 0, 32'd200);
    @(negedge clk);
    chk("R10 b2b call", 64'(call_pulse), 1);
    drive(8'h95, 16'd0, 0, 0, 0, 32'd201);
    @(negedge clk);
    chk("R11 b2b exit", 64'(exit_pulse), 1);
    chk("R10 b2b call drop", 64'(call_pulse), 0);
    drive(8'h05, 16'd4, 0, 0, 0, 32'd202);
    @(negedge clk);
    issue = 1'b0;
    chk("R11 b2b exit drop", 64'(exit_pulse), 0);
    chk("R9 b2b taken", 64'(taken), 1);
    chk("R10 b2b helper kept", 64'(helper_id), 64'hBEEF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_always();
    t_equality();
    t_imm_ext();
    t_unsigned();
    t_signed();
    t_narrow();
    t_pc_math();
    t_call_exit();
    t_illegal();
    t_idle();
    t_overlap();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule